// File: doc/BRIEF.md
# Edge-to-Pulse Isolation Encoder with Level Refresh

This block is the transmit half of a pulse-coupled isolation link, described as synchronous logic. A single data bit enters through a synchroniser. Every change of that bit becomes a short strobe on one of two output channels. A strobe on the set channel marks a rise and a strobe on the clear channel marks a fall. A receiver built as a simple set/reset latch can therefore rebuild the waveform from the strobes alone.

Because only edges cross the link, a receiver that misses a strobe, or that powers up late, could hold the wrong level. To prevent this the block re-sends the present level as a strobe on the matching channel after every `REFRESH_CYCLES` clock cycles without any other strobe. It keeps doing so for as long as the input stays quiet. It also sends one strobe of the present level as soon as the synchroniser holds valid data after reset.

Strobe width (`PULSE_CYCLES`), idle interval (`REFRESH_CYCLES`) and synchroniser depth (`SYNC_STAGES`) are parameters given in clock cycles.

Top module: `iso_tx_enc`

## Requirements
- R1: With `SYNC_STAGES`=2, a value of `din_i` sampled at clock edge m that differs from the value sampled at edge m-1 starts a strobe that is visible on the outputs after edge m+2.
- R2: A change from 0 to 1 (as seen after synchronisation) produces a strobe on `set_o` only.
- R3: A change from 1 to 0 (as seen after synchronisation) produces a strobe on `clr_o` only.
- R4: Each strobe holds its output high for exactly `PULSE_CYCLES` consecutive cycles. A new strobe that starts while one is active cuts it off, takes over the channel given by the new polarity, and runs its own full width.
- R5: When `REFRESH_CYCLES` cycles pass after the last strobe trigger with no new edge, a refresh strobe is sent on the channel of the present synchronised level (1 on `set_o`, 0 on `clr_o`). It repeats every `REFRESH_CYCLES` cycles while the input stays constant.
- R6: Every detected edge restarts the idle interval, so no refresh strobe starts fewer than `REFRESH_CYCLES` cycles after an edge strobe. The outputs stay low whenever no strobe is active.
- R7: After reset is released, once the synchroniser has filled (trigger in the cycle after edge `SYNC_STAGES`), one strobe of the synchronised level is sent without waiting for an edge or for a refresh. With `SYNC_STAGES`=2 it is visible after edge 3 and reflects `din_i` as sampled at edge 1.
- R8: `set_o` and `clr_o` are never high in the same cycle.
- R9: While `rst_ni` is low both outputs are low, and asserting `rst_ni` clears an active strobe at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | 1 | Asynchronous data bit to transmit |
| set_o | output | 1 | Strobe for a rise or for a high level refresh |
| clr_o | output | 1 | Strobe for a fall or for a low level refresh |

## Verification
The hardest situation to reach is a refresh deadline that lands exactly on, or just next to, a data edge. That is also where a strobe would be replaced by one of opposite polarity before its width has run out. To get there, the bench sweeps every 8-bit pattern at hold times of one, two and three cycles, and places idle gaps of varying length between patterns. This makes edges fall at every offset from the refresh deadline. The bench also asserts reset in the middle of the start-up strobe to show that the strobe is cut off asynchronously.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

  typedef enum logic {
    POL_CLR = 1'b0,
    POL_SET = 1'b1
  } pol_e;

  typedef struct packed {
    logic vld;
    pol_e pol;
  } trig_t;

endpackage

// File: rtl/iso_tx_sync.sv
module iso_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic lvl_o,
  output logic ready_o
);

  localparam int WW = $clog2(STAGES + 1);
  localparam logic [WW-1:0] WARM_END = WW'(STAGES);

  logic [STAGES-1:0] chain_q;
  logic [WW-1:0]     warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= din_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  // counts edges until the chain holds sampled data only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                warm_q <= '0;
    else if (warm_q != WARM_END) warm_q <= warm_q + 1'b1;
  end

  assign lvl_o   = chain_q[STAGES-1];
  assign ready_o = (warm_q == WARM_END);

  generate
    if (STAGES == 2) begin : g_chk2
      p_sync_delay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (lvl_o == $past(din_i, 2)));
    end
  endgenerate

endmodule

// File: rtl/iso_tx_edge.sv
module iso_tx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic ready_i,
  output logic edge_o,
  output logic start_o
);

  logic lvl_q;
  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      lvl_q     <= lvl_i;
      started_q <= ready_i;
    end
  end

  // start-up strobe in the first cycle with valid data; edges only after it
  assign start_o = ready_i && !started_q;
  assign edge_o  = started_q && (lvl_i != lvl_q);

  p_start_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_edge_change_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (lvl_i != $past(lvl_i)));

endmodule

// File: rtl/iso_tx_idle.sv
module iso_tx_idle #(
  parameter int REFRESH_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic start_i,
  output logic refresh_o
);

  localparam int CW = $clog2(REFRESH_CYCLES + 1);
  localparam logic [CW-1:0] CNT_END = CW'(REFRESH_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          any_trig;

  // zero means idle timer not yet armed (before the start-up strobe)
  assign refresh_o = (cnt_q == CNT_END) && !edge_i;
  assign any_trig  = edge_i || start_i || refresh_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (any_trig)                     cnt_q <= CW'(1);
    else if (cnt_q != '0 && cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_END);

  generate
    if (REFRESH_CYCLES > 1) begin : g_gap
      p_refresh_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_o |-> !$past(edge_i));
    end
  endgenerate

endmodule

// File: rtl/iso_tx_pulse.sv
module iso_tx_pulse
  import iso_tx_pkg::*;
#(
  parameter int PULSE_CYCLES = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  trig_t trig_i,
  output logic  set_o,
  output logic  clr_o
);

  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LEN = PW'(PULSE_CYCLES);

  logic [PW-1:0] left_q;
  pol_e          pol_q;
  logic          active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      pol_q  <= POL_CLR;
    end else if (trig_i.vld) begin
      left_q <= PULSE_LEN;
      pol_q  <= trig_i.pol;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active = (left_q != '0);
  assign set_o  = active && (pol_q == POL_SET);
  assign clr_o  = active && (pol_q == POL_CLR);

  p_width_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= PULSE_LEN);

  p_load_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i.vld |=> (left_q == PULSE_LEN));

endmodule

// File: rtl/iso_tx_enc.sv
module iso_tx_enc
  import iso_tx_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int PULSE_CYCLES   = 1,
  parameter int REFRESH_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic set_o,
  output logic clr_o
);

  logic  lvl;
  logic  ready;
  logic  edge_hit;
  logic  start_hit;
  logic  refresh_hit;
  trig_t trig;

  iso_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (din_i),
    .lvl_o   (lvl),
    .ready_o (ready)
  );

  iso_tx_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl),
    .ready_i (ready),
    .edge_o  (edge_hit),
    .start_o (start_hit)
  );

  iso_tx_idle #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_hit),
    .start_i   (start_hit),
    .refresh_o (refresh_hit)
  );

  // every trigger kind carries the present synchronised level as polarity
  assign trig.vld = edge_hit || start_hit || refresh_hit;
  assign trig.pol = lvl ? POL_SET : POL_CLR;

  iso_tx_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .set_o  (set_o),
    .clr_o  (clr_o)
  );

  p_mutex_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_o && clr_o));

  p_one_trig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({edge_hit, start_hit, refresh_hit}));

  p_set_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(set_o) |-> $past(trig.vld && trig.pol == POL_SET));

  p_clr_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_o) |-> $past(trig.vld && trig.pol == POL_CLR));

endmodule

// File: tb/tb_iso_tx_enc.sv
module tb_iso_tx_enc;

  localparam int CLK_PERIOD = 10;
  localparam int P = 2;
  localparam int R = 8;
  localparam int DEPTH = 32768;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic din = 1'b0;
  logic set_o;
  logic clr_o;

  int k;
  int lt_j;
  int lt_kind;
  bit lt_pol;
  int n_chk = 0;
  int n_fail = 0;
  bit d [DEPTH];

  iso_tx_enc #(
    .SYNC_STAGES(2),
    .PULSE_CYCLES(P),
    .REFRESH_CYCLES(R)
  ) dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .din_i  (din),
    .set_o  (set_o),
    .clr_o  (clr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check_out();
    bit act;
    bit es;
    bit ec;
    string tag;
    act = (lt_j > 0) && (k >= lt_j + 1) && (k <= lt_j + P);
    es  = act && lt_pol;
    ec  = act && !lt_pol;
    if (!act)              tag = "R4 R6 quiet";
    else if (lt_kind == 0) tag = "R7 start-up";
    else if (lt_kind == 2) tag = "R5 refresh";
    else if (lt_pol)       tag = "R1 R2 R4 rise";
    else                   tag = "R1 R3 R4 fall";
    n_chk++;
    if ({set_o, clr_o} != {es, ec}) begin
      n_fail++;
      $display("FAIL %s at edge %0d: set/clr actual %b%b expected %b%b",
               tag, k, set_o, clr_o, es, ec);
    end
    n_chk++;
    if (set_o && clr_o) begin
      n_fail++;
      $display("FAIL R8 at edge %0d: set/clr actual 11 expected not both", k);
    end
  endtask

  // trigger decided in the cycle after edge k, from levels sampled at k-1, k-2
  task automatic eval_trig();
    if (k == 2) begin
      lt_j = k; lt_pol = d[1]; lt_kind = 0;
    end else if (k >= 3 && d[k-1] != d[k-2]) begin
      lt_j = k; lt_pol = d[k-1]; lt_kind = 1;
    end else if (lt_j > 0 && k - lt_j == R) begin
      lt_j = k; lt_pol = d[k-1]; lt_kind = 2;
    end
  endtask

  task automatic cyc(input bit v);
    @(negedge clk);
    check_out();
    eval_trig();
    din = v;
    if (k + 1 < DEPTH) d[k+1] = v;
    @(posedge clk);
    k++;
  endtask

  task automatic do_reset(input bit v);
    @(negedge clk);
    rst_ni = 1'b0;
    din = v;
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (set_o || clr_o) begin
        n_fail++;
        $display("FAIL R9 in reset: set/clr actual %b%b expected 00", set_o, clr_o);
      end
    end
    rst_ni = 1'b1;
    din = v;
    d[1] = v;
    k = 0;
    lt_j = 0;
    lt_pol = 1'b0;
    lt_kind = 0;
    @(posedge clk);
    k = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: cycles actual 200000 expected fewer");
    summary();
    $finish;
  end

  initial begin
    // R7 R5: start-up clear strobe then periodic refresh at low level
    do_reset(1'b0);
    repeat (40) cyc(1'b0);
    // R2 R5 R6: rise, then high-level refresh
    repeat (30) cyc(1'b1);
    // R3 R5 R6: fall, then low-level refresh
    repeat (30) cyc(1'b0);

    // R7: start-up strobe on set channel
    do_reset(1'b1);
    repeat (20) cyc(1'b1);

    // R1-style sweep: every 8-bit pattern, hold 1..3, varying idle gap
    for (int p = 0; p < 256; p++) begin
      for (int h = 1; h <= 3; h++) begin
        for (int b = 0; b < 8; b++) begin
          repeat (h) cyc(p[b]);
        end
        repeat (p % 8) cyc(p[7]);
      end
    end
    repeat (3 * R) cyc(1'b0);

    // R9: asynchronous reset in the middle of the start-up strobe
    do_reset(1'b1);
    cyc(1'b1);
    cyc(1'b1);
    @(negedge clk);
    check_out();
    rst_ni = 1'b0;
    #1;
    n_chk++;
    if (set_o || clr_o) begin
      n_fail++;
      $display("FAIL R9 async clear: set/clr actual %b%b expected 00", set_o, clr_o);
    end
    do_reset(1'b0);
    repeat (2 * R + 4) cyc(1'b0);

    summary();
    $finish;
  end

endmodule